// File: doc/BRIEF.md
# SIMD Saturating Variable Shifter

This block is a packed-vector arithmetic stage. It treats a first operand as a row of equal-width integer lanes and moves each lane by its own signed amount. The amount for a lane is the bottom byte of the lane in the same position of a second operand. A positive amount moves the lane toward the most significant end, and any result that no longer fits is clamped to the nearest representable value. A zero or negative amount moves the lane toward the least significant end by the magnitude of the amount, and the bits that fall off are simply dropped.

Lanes may be 8, 16, 32 or 64 bits wide. They are read as signed or unsigned according to a mode input. The vector may be 64 or 128 bits long. Each accepted operation produces a registered result, one saturation bit per lane, and an update to a sticky flag. The flag records that some lane has clamped since it was last cleared. The flag is held in a two-state machine with the states FLAG_CLEAR and FLAG_SET. The transition *arm* goes from FLAG_CLEAR to FLAG_SET when an accepted operation saturates. The transition *wipe* goes from FLAG_SET to FLAG_CLEAR on a clear request that comes with no new saturation. In every other case the state *holds*.

Top module: `vsat_shift_top`

## Requirements
- R1: Each lane's amount is bits [7:0] of the matching lane of `opb`, read as two's complement. The remaining bits of that lane of `opb` have no effect. An amount above zero moves the lane left. An amount of zero or below moves it right by the magnitude.
- R2: A right move truncates. Signed lanes fill with copies of the sign bit and unsigned lanes fill with zeros. A right amount equal to or above the lane width gives 0 for unsigned lanes, and for signed lanes gives -1 for negative inputs and 0 otherwise.
- R3: `lane_sel` codes 00, 01, 10 and 11 select 8, 16, 32 and 64-bit lanes. Lane i occupies bits [i*W +: W], and `lane_sat[i]` belongs to lane i. `lane_sat` bits at and above the lane count are 0.
- R4: `uns_mode`=1 selects unsigned lanes and 0 selects signed lanes. An unsigned left move that loses a set bit gives all ones and sets that lane's `lane_sat` bit.
- R5: A signed left move that overflows gives the most positive value for a non-negative input and the most negative value for a negative input, and sets that lane's `lane_sat` bit. A result that fits leaves the bit at 0.
- R6: A left amount equal to or above the lane width saturates any nonzero input. A zero input always gives 0 with no saturation, whatever the amount.
- R7: `wide_mode`=0 selects a 64-bit vector. In that mode `res_out[127:64]` is 0, the `lane_sat` bits of lanes in the upper half are 0, and the upper half cannot set the sticky flag. `wide_mode`=1 processes all 128 bits.
- R8: `res_out` and `lane_sat` update on the clock edge that samples `in_valid`=1, and `res_valid` is 1 for exactly the following cycle. Without `in_valid` both outputs hold their values. Reset sets all outputs to 0.
- R9: `sat_sticky` goes to 1 at the edge that accepts an operation in which any active lane saturates. It stays at 1 until `sticky_clr` is sampled in a cycle that brings no new saturation, and it falls at that edge. When a clear and a new saturation arrive in the same cycle, the flag is 1. Reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are present this cycle |
| lane_sel | input | 2 | Lane width code (00=8, 01=16, 10=32, 11=64) |
| uns_mode | input | 1 | 1 = unsigned lanes, 0 = signed lanes |
| wide_mode | input | 1 | 1 = 128-bit vector, 0 = 64-bit vector |
| opa | input | 128 | Lanes to be shifted |
| opb | input | 128 | Per-lane signed amounts in the bottom byte of each lane |
| sticky_clr | input | 1 | Request to clear the sticky flag |
| res_out | output | 128 | Registered result vector |
| lane_sat | output | 16 | Registered per-lane saturation bits |
| res_valid | output | 1 | Result registered from an accepted operation |
| sat_sticky | output | 1 | Cumulative saturation flag |

## Verification
Directed cases come first. Small left amounts on values that fit show that the lanes line up and that amounts are taken from the bottom byte only, because the upper bits of `opb` carry junk. Inputs sitting just at the signed or unsigned limits, shifted by one, separate the positive clamp from the negative clamp and from the all-ones clamp. Out-of-range amounts of both signs, applied to zero, positive and negative lanes, separate sign fill from zero fill and show that zero inputs never saturate. After these, a few hundred seeded random operations mix every lane size, signedness, vector width and amounts clustered around the lane width. The 64-bit vector mode is run with overflowing upper lanes to show that the upper half drops out of both the result and the flag.

// File: rtl/vss_pkg.sv
package vss_pkg;

    typedef enum logic [1:0] {
        LANE_B8  = 2'b00,
        LANE_B16 = 2'b01,
        LANE_B32 = 2'b10,
        LANE_B64 = 2'b11
    } lane_size_e;

    typedef enum logic {
        FLAG_CLEAR = 1'b0,
        FLAG_SET   = 1'b1
    } flag_state_e;

    localparam int unsigned NUM_SIZES   = 4;
    localparam int unsigned MIN_LANE_W  = 8;
    localparam int unsigned SHAMT_W     = 8;

endpackage

// File: rtl/vss_lane_shift.sv
module vss_lane_shift #(
    parameter int unsigned LANE_W = 8,
    parameter int unsigned AMT_W  = 8
) (
    input  logic [LANE_W-1:0] a_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic              uns_i,
    output logic [LANE_W-1:0] res_o,
    output logic              sat_o
);

    logic                     amt_neg;
    logic [AMT_W-1:0]         mag;
    logic [31:0]              mag32;
    logic                     go_left;
    logic                     too_far;
    logic                     neg_in;
    logic [LANE_W-1:0]        left_v;
    logic signed [LANE_W-1:0] a_s;
    logic signed [LANE_W-1:0] back_s;
    logic [LANE_W-1:0]        pos_lim;
    logic [LANE_W-1:0]        neg_lim;

    always_comb begin
        amt_neg = amt_i[AMT_W-1];
        mag     = amt_neg ? (~amt_i + AMT_W'(1)) : amt_i;
        mag32   = 32'(mag);
        go_left = !amt_neg && (amt_i != '0);
        too_far = (mag32 >= LANE_W);
        neg_in  = !uns_i && a_i[LANE_W-1];
        a_s     = $signed(a_i);
        left_v  = a_i << mag;
        back_s  = $signed(left_v) >>> mag;
        pos_lim = uns_i ? {LANE_W{1'b1}} : {1'b0, {(LANE_W-1){1'b1}}};
        neg_lim = {1'b1, {(LANE_W-1){1'b0}}};

        res_o = '0;
        sat_o = 1'b0;
        if (go_left) begin
            if (a_i == '0) begin
                res_o = '0;
                sat_o = 1'b0;
            end else begin
                if (too_far) begin
                    sat_o = 1'b1;
                end else if (uns_i) begin
                    sat_o = ((left_v >> mag) != a_i);
                end else begin
                    sat_o = (back_s != a_s);
                end
                if (sat_o) begin
                    res_o = neg_in ? neg_lim : pos_lim;
                end else begin
                    res_o = left_v;
                end
            end
        end else begin
            if (too_far) begin
                res_o = neg_in ? {LANE_W{1'b1}} : '0;
            end else if (uns_i) begin
                res_o = a_i >> mag;
            end else begin
                res_o = $unsigned(a_s >>> mag);
            end
        end

        if (!$isunknown(a_i) && (a_i == '0)) begin
            AST_ZERO_NO_SAT: assert (!sat_o) else $error("zero lane saturated"); // R6
        end
        if (!$isunknown({uns_i, sat_o}) && uns_i && sat_o) begin
            AST_UNS_CLAMP_ONES: assert (res_o == {LANE_W{1'b1}}) else $error("unsigned clamp not all ones"); // R4
        end
    end

endmodule

// File: rtl/vss_lane_array.sv
module vss_lane_array #(
    parameter int unsigned VEC_W      = 128,
    parameter int unsigned LANE_W     = 8,
    parameter int unsigned AMT_W      = 8,
    parameter int unsigned MAX_LANES  = 16,
    localparam int unsigned NUM_LANES = VEC_W / LANE_W,
    localparam int unsigned HALF_LANES = NUM_LANES / 2
) (
    input  logic [VEC_W-1:0]           a_i,
    input  logic [NUM_LANES*AMT_W-1:0] amt_i,
    input  logic                       uns_i,
    input  logic                       wide_i,
    output logic [VEC_W-1:0]           res_o,
    output logic [MAX_LANES-1:0]       sat_o
);

    genvar li;
    generate
        for (li = 0; li < MAX_LANES; li++) begin : g_lane
            if (li < NUM_LANES) begin : g_used
                logic [LANE_W-1:0] r_l;
                logic              s_l;
                logic              active;

                vss_lane_shift #(
                    .LANE_W (LANE_W),
                    .AMT_W  (AMT_W)
                ) u_lane (
                    .a_i   (a_i[li*LANE_W +: LANE_W]),
                    .amt_i (amt_i[li*AMT_W +: AMT_W]),
                    .uns_i (uns_i),
                    .res_o (r_l),
                    .sat_o (s_l)
                );

                if (li < HALF_LANES) begin : g_low
                    assign active = 1'b1;
                end else begin : g_high
                    assign active = wide_i;
                end

                assign res_o[li*LANE_W +: LANE_W] = active ? r_l : '0;
                assign sat_o[li]                  = active & s_l;
            end else begin : g_unused
                assign sat_o[li] = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/vss_sticky_flag.sv
module vss_sticky_flag
    import vss_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    flag_state_e state_q;
    flag_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: begin
                if (set_i) state_d = FLAG_SET;           // arm
            end
            FLAG_SET: begin
                if (clr_i && !set_i) state_d = FLAG_CLEAR; // wipe
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        flag_o = (state_q == FLAG_SET);
    end

    AST_FLAG_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o) else $error("flag not set after saturation"); // R9
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o) else $error("flag dropped without clear"); // R9
    AST_FLAG_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o) else $error("flag not cleared"); // R9

endmodule

// File: rtl/vsat_shift_top.sv
module vsat_shift_top
    import vss_pkg::*;
#(
    parameter int unsigned VEC_W = 128,
    localparam int unsigned MAX_LANES = VEC_W / MIN_LANE_W,
    localparam int unsigned HALF_W    = VEC_W / 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [1:0]           lane_sel,
    input  logic                 uns_mode,
    input  logic                 wide_mode,
    input  logic [VEC_W-1:0]     opa,
    input  logic [VEC_W-1:0]     opb,
    input  logic                 sticky_clr,
    output logic [VEC_W-1:0]     res_out,
    output logic [MAX_LANES-1:0] lane_sat,
    output logic                 res_valid,
    output logic                 sat_sticky
);

    logic [VEC_W-1:0]     res_by_size [NUM_SIZES];
    logic [MAX_LANES-1:0] sat_by_size [NUM_SIZES];
    logic [VEC_W-1:0]     res_nxt;
    logic [MAX_LANES-1:0] sat_nxt;
    logic [VEC_W-1:0]     res_q;
    logic [MAX_LANES-1:0] sat_q;
    logic                 vld_q;
    logic                 sat_event;
    lane_size_e           size_sel;

    genvar gi, li;
    generate
        for (gi = 0; gi < NUM_SIZES; gi++) begin : g_size
            localparam int unsigned LW = MIN_LANE_W << gi;
            localparam int unsigned NL = VEC_W / LW;
            logic [NL*SHAMT_W-1:0] amts;

            for (li = 0; li < NL; li++) begin : g_amt
                assign amts[li*SHAMT_W +: SHAMT_W] = opb[li*LW +: SHAMT_W];
            end

            vss_lane_array #(
                .VEC_W     (VEC_W),
                .LANE_W    (LW),
                .AMT_W     (SHAMT_W),
                .MAX_LANES (MAX_LANES)
            ) u_array (
                .a_i    (opa),
                .amt_i  (amts),
                .uns_i  (uns_mode),
                .wide_i (wide_mode),
                .res_o  (res_by_size[gi]),
                .sat_o  (sat_by_size[gi])
            );
        end
    endgenerate

    always_comb begin
        size_sel = lane_size_e'(lane_sel);
        unique case (size_sel)
            LANE_B8:  begin res_nxt = res_by_size[0]; sat_nxt = sat_by_size[0]; end
            LANE_B16: begin res_nxt = res_by_size[1]; sat_nxt = sat_by_size[1]; end
            LANE_B32: begin res_nxt = res_by_size[2]; sat_nxt = sat_by_size[2]; end
            LANE_B64: begin res_nxt = res_by_size[3]; sat_nxt = sat_by_size[3]; end
        endcase
        sat_event = in_valid && (sat_nxt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            sat_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                res_q <= res_nxt;
                sat_q <= sat_nxt;
            end
        end
    end

    vss_sticky_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (sat_event),
        .clr_i  (sticky_clr),
        .flag_o (sat_sticky)
    );

    always_comb begin
        res_out   = res_q;
        lane_sat  = sat_q;
        res_valid = vld_q;
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid) else $error("missing result strobe"); // R8
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid) else $error("spurious result strobe"); // R8
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(res_out) && $stable(lane_sat))) else $error("result changed while idle"); // R8
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide_mode) |=> (res_out[VEC_W-1:HALF_W] == '0)) else $error("upper half not zero"); // R7
    AST_D64_SAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_sel == 2'b11) |=> (lane_sat[MAX_LANES-1:2] == '0)) else $error("sat bit beyond lane count"); // R3

endmodule

// File: tb/tb_vsat_shift_top.sv
module tb_vsat_shift_top;

    localparam realtime HALF_PER = 2.5ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   lane_sel = 2'b00;
    logic         uns_mode = 1'b0;
    logic         wide_mode = 1'b1;
    logic [127:0] opa = '0;
    logic [127:0] opb = '0;
    logic         sticky_clr = 1'b0;
    logic [127:0] res_out;
    logic [15:0]  lane_sat;
    logic         res_valid;
    logic         sat_sticky;

    int n_checks = 0;
    int n_errors = 0;
    logic exp_flag = 1'b0;

    always #(HALF_PER) clk = ~clk;

    vsat_shift_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .lane_sel   (lane_sel),
        .uns_mode   (uns_mode),
        .wide_mode  (wide_mode),
        .opa        (opa),
        .opb        (opb),
        .sticky_clr (sticky_clr),
        .res_out    (res_out),
        .lane_sat   (lane_sat),
        .res_valid  (res_valid),
        .sat_sticky (sat_sticky)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void ref_lane(input logic [63:0] a, input logic [7:0] amt, input int lw,
                                     input logic uns, output logic [63:0] r, output logic s);
        logic signed [199:0] v, t, hi, lo;
        logic [63:0] lmask;
        int n;
        lmask = (lw == 64) ? {64{1'b1}} : ((64'd1 << lw) - 64'd1);
        v = $signed({136'd0, a & lmask});
        if (!uns && a[lw-1]) v = v - (200'sd1 <<< lw);
        hi = uns ? ((200'sd1 <<< lw) - 200'sd1) : ((200'sd1 <<< (lw-1)) - 200'sd1);
        lo = uns ? 200'sd0 : -(200'sd1 <<< (lw-1));
        n = int'($signed(amt));
        s = 1'b0;
        if (n > 0) begin
            t = v <<< n;
            if (t > hi) begin s = 1'b1; t = hi; end
            else if (t < lo) begin s = 1'b1; t = lo; end
        end else begin
            t = v >>> (-n);
        end
        r = t[63:0] & lmask;
    endfunction

    function automatic void ref_vec(input logic [127:0] a, input logic [127:0] b, input logic [1:0] sel,
                                    input logic uns, input logic wide,
                                    output logic [127:0] rv, output logic [15:0] sv);
        int lw, nl;
        logic [63:0] rl;
        logic sl;
        lw = 8 << sel;
        nl = 128 / lw;
        rv = '0;
        sv = '0;
        for (int li = 0; li < nl; li++) begin
            ref_lane(64'(a >> (li*lw)), 8'(b >> (li*lw)), lw, uns, rl, sl);
            if (wide || li < nl/2) begin
                rv = rv | (128'(rl) << (li*lw));
                sv[li] = sl;
            end
        end
    endfunction

    // one accepted operation; called at a negedge, returns at the next negedge
    task automatic run_op(input string tag, input logic [127:0] a, input logic [127:0] b,
                          input logic [1:0] sel, input logic uns, input logic wide, input logic clr);
        logic [127:0] er;
        logic [15:0]  es;
        opa = a; opb = b; lane_sel = sel; uns_mode = uns; wide_mode = wide;
        sticky_clr = clr; in_valid = 1'b1;
        ref_vec(a, b, sel, uns, wide, er, es);
        exp_flag = (exp_flag & ~clr) | (es != '0);
        @(negedge clk);
        in_valid = 1'b0; sticky_clr = 1'b0;
        chk({tag, " res"}, res_out, er);
        chk({tag, " sat"}, 128'(lane_sat), 128'(es));
        chk("R8 valid strobe", 128'(res_valid), 128'd1);
        chk("R9 sticky", 128'(sat_sticky), 128'(exp_flag));
    endtask

    function automatic logic [127:0] fill_amts(input logic [127:0] junk, input logic [1:0] sel, input logic [7:0] amt);
        logic [127:0] b;
        int lw;
        lw = 8 << sel;
        b = junk;
        for (int li = 0; li < 128/lw; li++) b[li*lw +: 8] = amt;
        return b;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        #(HALF_PER * 2 * 200000);
        n_errors++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [127:0] held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 reset res", res_out, '0);
        chk("R8 reset sat", 128'(lane_sat), '0);
        chk("R8 reset valid", 128'(res_valid), '0);
        chk("R9 reset sticky", 128'(sat_sticky), '0);

        // R1: signed 8-bit lanes, amount +1 from low byte; hand value for lane 0
        run_op("R1 left by one", {16{8'h11}}, {16{8'h01}}, 2'b00, 1'b0, 1'b1, 1'b0);
        chk("R1 lane0 value", 128'(res_out[7:0]), 128'h22);
        // R1: junk in upper bits of amount lanes must not matter
        run_op("R1 junk upper", {8{16'h0123}}, fill_amts({8{16'hA500}}, 2'b01, 8'd4), 2'b01, 1'b1, 1'b1, 1'b0);
        chk("R1 junk lane0", 128'(res_out[15:0]), 128'h1230);
        // R2: signed right, sign fill
        run_op("R2 signed right", {4{32'h8000_0010}}, fill_amts('0, 2'b10, 8'hFC), 2'b10, 1'b0, 1'b1, 1'b0);
        chk("R2 sign fill", 128'(res_out[31:0]), 128'hF800_0001);
        run_op("R2 unsigned right", {4{32'h8000_0010}}, fill_amts('0, 2'b10, 8'hFC), 2'b10, 1'b1, 1'b1, 1'b0);
        chk("R2 zero fill", 128'(res_out[31:0]), 128'h0800_0001);
        run_op("R2 far right signed", {2{64'h8000_0000_0000_0001}}, fill_amts('0, 2'b11, 8'h80), 2'b11, 1'b0, 1'b1, 1'b0);
        chk("R2 far right -1", res_out, {128{1'b1}});
        run_op("R2 far right unsigned", {2{64'h8000_0000_0000_0001}}, fill_amts('0, 2'b11, 8'hC0), 2'b11, 1'b1, 1'b1, 1'b0);
        // R3: 64-bit lanes only two sat bits
        run_op("R3 d64 lanes", {64'h1, 64'hFFFF_FFFF_FFFF_FFFF}, fill_amts('0, 2'b11, 8'd1), 2'b11, 1'b1, 1'b1, 1'b0);
        chk("R3 sat bits", 128'(lane_sat), 128'h1);
        // R4: unsigned overflow clamps to ones
        run_op("R4 uns clamp", {16{8'h81}}, {16{8'h01}}, 2'b00, 1'b1, 1'b1, 1'b1);
        chk("R4 lane0 ones", 128'(res_out[7:0]), 128'hFF);
        // R5: signed clamps both ways
        run_op("R5 pos clamp", {8{16'h4000}}, fill_amts('0, 2'b01, 8'd1), 2'b01, 1'b0, 1'b1, 1'b0);
        chk("R5 max", 128'(res_out[15:0]), 128'h7FFF);
        run_op("R5 neg clamp", {8{16'hBFFF}}, fill_amts('0, 2'b01, 8'd1), 2'b01, 1'b0, 1'b1, 1'b0);
        chk("R5 min", 128'(res_out[15:0]), 128'h8000);
        run_op("R5 fits", {8{16'hC000}}, fill_amts('0, 2'b01, 8'd1), 2'b01, 1'b0, 1'b1, 1'b0);
        chk("R5 no sat", 128'(lane_sat), '0);
        // R6: far left, zero and nonzero lanes
        run_op("R6 far left", {120'd0, 8'h01}, {16{8'd100}}, 2'b00, 1'b0, 1'b1, 1'b0);
        chk("R6 sat pattern", 128'(lane_sat), 128'h1);
        run_op("R6 zero input", '0, {16{8'h7F}}, 2'b00, 1'b1, 1'b1, 1'b0);
        // R7: narrow mode; overflowing upper lanes ignored
        sticky_clr = 1'b1; @(negedge clk); sticky_clr = 1'b0; exp_flag = 1'b0;
        chk("R9 cleared", 128'(sat_sticky), '0);
        run_op("R7 narrow", {{64{1'b1}}, 64'h0101_0101_0101_0101}, {16{8'h01}}, 2'b00, 1'b1, 1'b0, 1'b0);
        chk("R7 upper zero", 128'(res_out[127:64]), '0);
        chk("R7 no flag", 128'(sat_sticky), '0);
        // R8: hold while idle with changed operands
        held = res_out;
        opa = rnd128(); opb = rnd128();
        @(negedge clk);
        chk("R8 idle no valid", 128'(res_valid), '0);
        chk("R8 held", res_out, held);
        // R9: clear together with saturation keeps flag
        run_op("R9 set", {16{8'h7F}}, {16{8'h01}}, 2'b00, 1'b0, 1'b1, 1'b0);
        run_op("R9 clr and sat", {16{8'h7F}}, {16{8'h01}}, 2'b00, 1'b0, 1'b1, 1'b1);
        run_op("R9 clr no sat", '0, '0, 2'b00, 1'b0, 1'b1, 1'b1);

        // random mix
        for (int k = 0; k < 400; k++) begin
            logic [1:0] sel;
            logic [127:0] a, b;
            int lw;
            sel = 2'($urandom);
            lw = 8 << sel;
            a = rnd128();
            if ($urandom % 8 == 0) a = '0;
            if ($urandom % 8 == 1) a = a >> ($urandom % 128);
            b = rnd128();
            for (int li = 0; li < 128/lw; li++) begin
                int pick;
                pick = $urandom % 4;
                if (pick == 1 || pick == 2) b[li*lw +: 8] = 8'(int'($urandom % (2*lw+9)) - (lw+4));
                else if (pick == 3) b[li*lw +: 8] = 8'($urandom % 4);
            end
            run_op("R1 R2 R4 R5 random", a, b, sel, 1'($urandom), 1'($urandom), 1'($urandom % 6 == 0));
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule